// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns a free-running reference clock enable into the oversampling tick that a UART receiver and transmitter count, plus a strobe that marks each bit time. The division ratio is a 16-bit whole number of reference periods plus a fraction in sixteenths. The fraction is spread over the ticks by a phase accumulator, so no rate error builds up over time. A rate field can shorten a bit to 8 or 4 ticks instead of 16, which doubles or quadruples the bit rate for the same divisor.

The divisor arrives as two bytes: a low byte and a high byte. The fraction and the rate field share one configuration byte. All of these are sampled only when a tick period ends, so software can rewrite them while the block runs. A whole number of zero parks the generator, and it starts again as soon as a nonzero value appears. For example, a 13 MHz reference at 115200 baud needs whole part 7 and fraction 1. The same reference at 460800 baud needs whole part 1 and fraction 12. Selecting the double rate with that same setting gives 921600 baud.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `os_tick` and `bit_stb` are low. Reset leaves the generator parked.
- R2: The whole part D is `{div_hi, div_lo}`. With fraction 0 and `ref_en` held high, every tick period lasts exactly D clock cycles. This holds for values that use the high byte.
- R3: The fraction F is `cfg[3:0]`, in sixteenths. Each tick period lasts D or D+1 enabled reference cycles. Any 16 consecutive periods together last exactly 16·D+F enabled cycles.
- R4: Only cycles with `ref_en` high advance the period count. A tick never follows a cycle in which `ref_en` was low.
- R5: With `cfg[5:4]` = 00, `bit_stb` pulses on every 16th tick.
- R6: With `cfg[4]` = 1 and `cfg[5]` = 0, `bit_stb` pulses on every 8th tick. With `cfg[5]` = 1, it pulses on every 4th tick whatever `cfg[4]` holds.
- R7: When D = 0 is sampled at a period boundary, the generator parks after finishing the current period, and no further tick appears whatever F holds. From the park state, a nonzero D written at a falling-edge drive gives the first tick D+1 cycles later when `ref_en` is high.
- R8: D, F and the rate field are sampled only at a period boundary. A change made during a period leaves the length of that period unchanged, and the next period uses the new value.
- R9: `os_tick` is a registered one-cycle pulse. It is high in the cycle after the enabled reference cycle that completes a period.
- R10: `bit_stb` is high only in a cycle where `os_tick` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference clock enable; one count per high cycle |
| div_lo | input | 8 | Low byte of the whole-number divisor |
| div_hi | input | 8 | High byte of the whole-number divisor |
| cfg | input | 8 | [3:0] fraction in sixteenths, [4] double rate, [5] quadruple rate |
| os_tick | output | 1 | Oversampling tick pulse |
| bit_stb | output | 1 | Bit-time strobe, coincident with a tick |

## Verification
Two events can fall in the same clock: a period boundary, where the divisor, fraction and rate are reloaded, and an input change that lands exactly on that boundary's enabled cycle. The same boundary can also end a bit, so a rate change can meet a strobe decision. The bench provokes these collisions with a randomised phase. It gates `ref_en` and rewrites the divisor and the rate field at pseudo-random moments, so some writes land on the completing cycle and some land just before it. A behavioural model counts down the remaining enabled cycles and keeps its phase as an integer. It is compared with both outputs on every clock. Directed spans then judge the period lengths, the strobe spacing and the park and restart latency against values worked out from the requirements.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    localparam int DIV_W  = 16;
    localparam int FRAC_W = 4;
    localparam int SUB_W  = 4;

    typedef enum logic [1:0] {
        RATE_X1 = 2'd0,
        RATE_X2 = 2'd1,
        RATE_X4 = 2'd2
    } rate_e;

    typedef struct packed {
        logic [DIV_W:0]    len;
        logic [FRAC_W-1:0] acc;
    } period_t;

    // Quadruple wins over double when both selects are set.
    function automatic rate_e decode_rate(input logic sel2x, input logic sel4x);
        if (sel4x)      return RATE_X4;
        else if (sel2x) return RATE_X2;
        else            return RATE_X1;
    endfunction

    function automatic logic [SUB_W-1:0] last_index(input rate_e r);
        case (r)
            RATE_X2: return SUB_W'(7);
            RATE_X4: return SUB_W'(3);
            default: return SUB_W'(15);
        endcase
    endfunction

    // Adds the fraction to the phase; a carry lengthens the period by one.
    function automatic period_t next_period(input logic [DIV_W-1:0]  whole,
                                            input logic [FRAC_W-1:0] frac,
                                            input logic [FRAC_W-1:0] phase);
        logic [FRAC_W:0] sum;
        period_t p;
        sum   = {1'b0, phase} + {1'b0, frac};
        p.len = {1'b0, whole} + {{DIV_W{1'b0}}, sum[FRAC_W]};
        p.acc = sum[FRAC_W-1:0];
        return p;
    endfunction

endpackage

// File: rtl/fbg_phase_ctr.sv
module fbg_phase_ctr
    import fbg_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int FW = FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_en,
    input  logic [DW-1:0] div_in,
    input  logic [FW-1:0] frac_in,
    input  rate_e         rate_in,
    output logic          fire,
    output logic          tick_q,
    output rate_e         rate_cur
);

    logic          run;
    logic [DW:0]   len;
    logic [DW:0]   cnt;
    logic [FW-1:0] acc;
    logic [DW-1:0] div_s;
    rate_e         rate_q;
    period_t       np;

    assign np       = next_period(div_in, frac_in, acc);
    assign fire     = run && ref_en && (cnt == len - 1'b1);
    assign rate_cur = rate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            len    <= '0;
            cnt    <= '0;
            acc    <= '0;
            div_s  <= '0;
            rate_q <= RATE_X1;
            tick_q <= 1'b0;
        end else begin
            tick_q <= fire;
            if (!run || fire) begin
                cnt <= '0;
                if (div_in != '0) begin
                    run    <= 1'b1;
                    len    <= np.len;
                    acc    <= np.acc;
                    div_s  <= div_in;
                    rate_q <= rate_in;
                end else begin
                    run   <= 1'b0;
                    acc   <= '0;
                    div_s <= '0;
                end
            end else if (ref_en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_len_span_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> ((len == {1'b0, div_s}) || (len == {1'b0, div_s} + 1'b1)));

    assert_run_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        run |-> (div_s != '0));

    assert_len_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(fire)) |-> $stable(len));

endmodule

// File: rtl/fbg_bit_div.sv
module fbg_bit_div
    import fbg_pkg::*;
#(
    parameter int SW = SUB_W
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  rate_e rate,
    output logic  stb_q
);

    logic [SW-1:0] subc;
    logic          wrap;

    assign wrap = (subc >= last_index(rate));

    always_ff @(posedge clk) begin
        if (rst) begin
            subc  <= '0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= fire && wrap;
            if (fire) begin
                subc <= wrap ? '0 : subc + 1'b1;
            end
        end
    end

    assert_sub_clear_R5: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> (subc == '0));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_en,
    input  logic [7:0] div_lo,
    input  logic [7:0] div_hi,
    input  logic [7:0] cfg,
    output logic       os_tick,
    output logic       bit_stb
);

    logic [DIV_W-1:0]  whole;
    logic [FRAC_W-1:0] frac;
    rate_e             rate_sel;
    rate_e             rate_run;
    logic              fire;

    assign whole    = {div_hi, div_lo};
    assign frac     = cfg[FRAC_W-1:0];
    assign rate_sel = decode_rate(cfg[4], cfg[5]);

    fbg_phase_ctr #(.DW(DIV_W), .FW(FRAC_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .ref_en   (ref_en),
        .div_in   (whole),
        .frac_in  (frac),
        .rate_in  (rate_sel),
        .fire     (fire),
        .tick_q   (os_tick),
        .rate_cur (rate_run)
    );

    fbg_bit_div #(.SW(SUB_W)) u_bits (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .rate  (rate_run),
        .stb_q (bit_stb)
    );

    assert_stb_tick_R10: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> os_tick);

    assert_tick_ref_R4: assert property (@(posedge clk) disable iff (rst)
        os_tick |-> $past(ref_en));

endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b1;
    logic [7:0] div_lo = 8'd0;
    logic [7:0] div_hi = 8'd0;
    logic [7:0] cfg = 8'd0;
    logic       os_tick;
    logic       bit_stb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ref_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    frac_baud_gen dut (
        .clk(clk), .rst(rst), .ref_en(ref_en), .div_lo(div_lo),
        .div_hi(div_hi), .cfg(cfg), .os_tick(os_tick), .bit_stb(bit_stb)
    );

    always #4 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit m_run = 0;
    int m_left = 0;
    int m_phase = 0;
    int m_sub = 0;
    int m_per = 16;
    bit exp_tick = 0;
    bit exp_stb = 0;

    function automatic int per_of(input logic [7:0] c);
        if (c[5]) return 4;
        if (c[4]) return 8;
        return 16;
    endfunction

    task automatic m_load();
        int d;
        d = {div_hi, div_lo};
        if (d != 0) begin
            m_run = 1;
            m_phase = m_phase + cfg[3:0];
            m_left = d + ((m_phase >= 16) ? 1 : 0);
            m_phase = m_phase % 16;
            m_per = per_of(cfg);
        end else begin
            m_run = 0;
            m_phase = 0;
        end
    endtask

    always @(posedge clk) begin
        exp_tick = 0;
        exp_stb = 0;
        if (rst) begin
            m_run = 0; m_phase = 0; m_sub = 0; m_left = 0; m_per = 16;
        end else if (!m_run) begin
            m_load();
        end else if (ref_en) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                exp_tick = 1;
                m_sub = m_sub + 1;
                if (m_sub >= m_per) begin
                    exp_stb = 1;
                    m_sub = 0;
                end
                m_load();
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, expv, cyc);
        end
    endtask

    // every clock: compare both outputs with the model (R9 timing, R4 gating, R10)
    always @(negedge clk) begin
        check(os_tick === exp_tick, "R9 model os_tick", int'(os_tick), int'(exp_tick));
        check(bit_stb === exp_stb, "R10 model bit_stb", int'(bit_stb), int'(exp_stb));
    end

    // reference enable driver and stimulus LFSR
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (ref_mode == 1)      ref_en <= ~ref_en;
        else if (ref_mode == 2) ref_en <= lfsr[0] | lfsr[3];
        else                    ref_en <= 1'b1;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    task automatic next_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!os_tick && n < 5000);
    endtask

    task automatic set_div(input int d, input logic [7:0] c);
        div_lo = d[7:0];
        div_hi = d[15:8];
        cfg = c;
    endtask

    task automatic span16(input int expv, input string tag);
        int n, tot, longp, d;
        d = {div_hi, div_lo};
        next_tick(n); next_tick(n);
        tot = 0; longp = 0;
        for (int i = 0; i < 16; i++) begin
            next_tick(n);
            tot += n;
            check((n == d) || (n == d + 1), tag, n, d);
            if (n == d + 1) longp++;
        end
        check(tot == expv, tag, tot, expv);
        check(longp == int'(cfg[3:0]), tag, longp, int'(cfg[3:0]));
    endtask

    task automatic stb_spacing(input int expv, input string tag);
        int t, s, g;
        s = 0; t = 0; g = 0;
        while (s < 3 && g < 20000) begin
            @(negedge clk);
            g++;
            if (os_tick) t++;
            if (bit_stb) begin
                if (s == 2) check(t == expv, tag, t, expv);
                s++;
                t = 0;
            end
        end
        check(s == 3, tag, s, 3);
    endtask

    initial begin
        int n, cnt;
        repeat (4) @(negedge clk);
        check(os_tick === 1'b0, "R1 reset os_tick", int'(os_tick), 0);
        check(bit_stb === 1'b0, "R1 reset bit_stb", int'(bit_stb), 0);
        rst = 1'b0;
        @(negedge clk);
        check(os_tick === 1'b0 && bit_stb === 1'b0, "R1 after reset", int'(os_tick), 0);

        // parked with D=0, F=0
        cnt = 0;
        repeat (60) begin @(negedge clk); if (os_tick) cnt++; end
        check(cnt == 0, "R7 zero divisor idle", cnt, 0);

        // R2: integer only, low byte and high byte
        set_div(5, 8'h00);
        span16(80, "R2 D=5");
        set_div(16'h0103, 8'h00);
        next_tick(n); next_tick(n);
        check(n == 259, "R2 high byte period", n, 259);

        // R3: fractional spans
        set_div(7, 8'h01);
        span16(113, "R3 D=7 F=1");
        set_div(84, 8'h0A);
        span16(1354, "R3 D=84 F=10");
        set_div(1, 8'h0C);
        span16(28, "R3 D=1 F=12");

        // R5 / R6: strobe spacing
        set_div(2, 8'h00);
        stb_spacing(16, "R5 x1 spacing");
        set_div(2, 8'h10);
        stb_spacing(8, "R6 x2 spacing");
        set_div(2, 8'h20);
        stb_spacing(4, "R6 x4 spacing");
        set_div(2, 8'h35);
        stb_spacing(4, "R6 both selects");

        // R8: change mid-period keeps the running length
        set_div(100, 8'h00);
        next_tick(n); next_tick(n);
        repeat (10) @(negedge clk);
        set_div(20, 8'h00);
        next_tick(n);
        check(n + 10 == 100, "R8 running period kept", n + 10, 100);
        next_tick(n);
        check(n == 20, "R8 new period applied", n, 20);

        // R7: park with nonzero fraction, then restart latency
        set_div(3, 8'h00);
        next_tick(n); next_tick(n);
        set_div(0, 8'h05);
        next_tick(n);
        check(n == 3, "R7 last period completes", n, 3);
        cnt = 0;
        repeat (300) begin @(negedge clk); if (os_tick) cnt++; end
        check(cnt == 0, "R7 no tick when parked", cnt, 0);
        set_div(3, 8'h00);
        next_tick(n);
        check(n == 4, "R7 restart latency", n, 4);

        // R4: reference enable every other cycle
        ref_mode = 1;
        next_tick(n); next_tick(n); next_tick(n);
        check(n == 6, "R4 gated reference period", n, 6);

        // randomised collisions of reloads with boundaries, judged by the model
        ref_mode = 2;
        for (int i = 0; i < 60; i++) begin
            repeat (int'(lfsr[4:0]) + 1) @(negedge clk);
            set_div((lfsr[9:8] == 2'b00 && lfsr[2]) ? 0 : int'(lfsr[7:6]) + 1,
                    {2'b00, lfsr[11:10], lfsr[15:12]});
        end
        set_div(2, 8'h00);
        ref_mode = 0;
        repeat (100) @(negedge clk);
        finish_run();
    end

endmodule